// File: doc/BRIEF.md
# Paged Program Window Address Translator

This block lets a CPU with 16-bit addresses reach a program store far larger than 64 KB. A fixed 16 KB slice of the CPU map, from 0x8000 to 0xBFFF, works as a window. An access that lands in the window is sent to a 20-bit program-memory address. The upper part of that address comes from a page index that software writes. The lower part is the offset of the access inside the window.

The page index is 6 bits wide, so 64 pages of 16 KB are reachable, which is 1 MB in total. Software reaches the block through a small register port. This port holds the page index and two read-only memory-size registers, whose constants are fixed when the block is integrated.

Translation is combinational from the stored index. A page change is therefore visible on the first access after the clock edge that completes the write.

Top module: `pgwin_xlate`

## Requirements
- R1: After reset the page index is zero: a read at offset 0x30 returns 0x00, and CPU address 0x8000 translates to 0x00000.
- R2: `in_window` is high for CPU addresses 0x8000 through 0xBFFF inclusive and low for every other address (for example 0x7FFF and 0xC000).
- R3: While `in_window` is high, `ext_addr[19:14]` equals the page index and `ext_addr[13:0]` equals `cpu_addr[13:0]`.
- R4: A write strobe at offset 0x30 stores `reg_wdata[5:0]` as the page index. A read at 0x30 returns the index in bits 5:0.
- R5: A page write takes effect at the clock edge that samples it. Until that edge, translation still uses the previous page. From that edge on, translation uses the new page.
- R6: A read at offset 0x1C returns parameter SIZE0_VAL (default 0x25), and a read at 0x1D returns SIZE1_VAL (default 0x81). Writes to these offsets change neither value.
- R7: Reads at any offset other than 0x1C, 0x1D and 0x30 return 0x00. Writes at such offsets leave the page index unchanged.
- R8: `reg_rdata` is 0x00 whenever `reg_rd` is low.
- R9: Bits 7:6 of the page register read as zero. Values written to those bits are discarded.
- R10: If a read and a write of offset 0x30 happen in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address of the current access |
| reg_ofs | input | 6 | Register offset for the register port |
| reg_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_rd | input | 1 | Register read strobe, read data is combinational |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, zero when no read |
| ext_addr | output | 20 | Extended program-memory address |
| in_window | output | 1 | Access falls in the paged window |

## Verification
The hardest case to reach is the boundary in time around a page write. The new page must stay hidden for the whole cycle that carries the write strobe, and it must appear immediately after the edge. The stimulus raises the write strobe and a read of the same offset away from the clock edge, with a window address held steady. It then samples the translated address and the read data just before the edge and again just after it. Window edges are covered by driving the four addresses on either side of both boundaries.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  localparam int CPU_AW  = 16;
  localparam int PAGE_W  = 6;
  localparam int OFS_W   = CPU_AW - 2;          // 16 KB window offset
  localparam int EXT_AW  = PAGE_W + OFS_W;      // 20-bit program address
  localparam int DATA_W  = 8;
  localparam int REG_AW  = 6;

  localparam logic [1:0]        WIN_TAG     = 2'b10;   // 0x8000..0xBFFF
  localparam logic [REG_AW-1:0] OFS_PAGE    = 6'h30;
  localparam logic [REG_AW-1:0] OFS_SIZE0   = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_SIZE1   = 6'h1D;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [EXT_AW-1:0] ext_t;

  function automatic logic win_hit(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1 -: 2] == WIN_TAG;
  endfunction

  function automatic ext_t xlate(input page_t pg, input logic [CPU_AW-1:0] a);
    return {pg, a[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg
  import pgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  output page_t             page
);
  logic wr_page_evt;
  logic unused_hi;

  assign wr_page_evt = wr_en && (wr_ofs == OFS_PAGE);
  assign unused_hi   = ^wr_data[DATA_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           page <= '0;
    else if (wr_page_evt) page <= wr_data[PAGE_W-1:0];
  end

  p_page_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_page_evt |=> page == $past(wr_data[PAGE_W-1:0]));

  p_page_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_page_evt |=> $stable(page));
endmodule

// File: rtl/pgwin_rd_mux.sv
module pgwin_rd_mux
  import pgwin_pkg::*;
#(
  parameter logic [DATA_W-1:0] SIZE0_VAL = 8'h25,
  parameter logic [DATA_W-1:0] SIZE1_VAL = 8'h81
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_ofs,
  input  page_t             page,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - PAGE_W;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (rd_ofs)
        OFS_PAGE:  rd_data = {{PAD_W{1'b0}}, page};
        OFS_SIZE0: rd_data = SIZE0_VAL;
        OFS_SIZE1: rd_data = SIZE1_VAL;
        default:   rd_data = '0;
      endcase
    end
  end

  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ofs == OFS_PAGE) |-> rd_data[DATA_W-1:PAGE_W] == '0);

  p_size_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ofs == OFS_SIZE0) |-> rd_data == SIZE0_VAL);
endmodule

// File: rtl/pgwin_map.sv
module pgwin_map
  import pgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  page_t             page,
  output ext_t              ext_addr,
  output logic              in_window
);
  assign in_window = win_hit(cpu_addr);
  assign ext_addr  = xlate(page, cpu_addr);

  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_window == (cpu_addr >= 16'h8000 && cpu_addr <= 16'hBFFF));

  p_xlate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (ext_addr - (EXT_AW'(page) << OFS_W)) == EXT_AW'(cpu_addr - 16'h8000));
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate
  import pgwin_pkg::*;
#(
  parameter logic [7:0] SIZE0_VAL = 8'h25,
  parameter logic [7:0] SIZE1_VAL = 8'h81
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [5:0]  reg_ofs,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [19:0] ext_addr,
  output logic        in_window
);
  page_t page_q;

  pgwin_page_reg u_page (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_ofs(reg_ofs),
    .wr_data(reg_wdata), .page(page_q));

  pgwin_rd_mux #(.SIZE0_VAL(SIZE0_VAL), .SIZE1_VAL(SIZE1_VAL)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .rd_ofs(reg_ofs),
    .page(page_q), .rd_data(reg_rdata));

  pgwin_map u_map (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .page(page_q),
    .ext_addr(ext_addr), .in_window(in_window));

  // R5/R10: a page write is invisible during its own cycle
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_ofs == OFS_PAGE) |=> $past(in_window) ->
      $past(ext_addr[19:14]) == $past(page_q));
endmodule

// File: tb/test_pgwin_xlate.sv
module test_pgwin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [5:0]  reg_ofs = 6'h00;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [19:0] ext_addr;
  logic        in_window;

  int n_total = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pgwin_xlate i_pgwin_xlate (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .reg_ofs(reg_ofs),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_addr(ext_addr), .in_window(in_window));

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_ext(input int pg, input int a);
    return pg * 16384 + (a - 32768);
  endfunction

  task automatic reg_write(input logic [5:0] ofs, input logic [7:0] d);
    @(negedge clk);
    reg_ofs = ofs; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] ofs, output logic [7:0] d);
    @(negedge clk);
    reg_ofs = ofs; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(6'h30, d);
    chk("R1 page after reset", d, 0);
    cpu_addr = 16'h8000; #1;
    chk("R1 ext after reset", ext_addr, 0);
  endtask

  task automatic t_window();
    int addrs [6] = '{16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'h0000, 16'hFFFF};
    int hits  [6] = '{0, 1, 1, 0, 0, 0};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); cpu_addr = addrs[i]; #1;
      chk("R2 window flag", in_window, hits[i]);
    end
  endtask

  task automatic t_translate();
    int pages [3] = '{6'h01, 6'h2A, 6'h3F};
    int addrs [3] = '{16'h8000, 16'hA5A5, 16'hBFFF};
    for (int i = 0; i < 3; i++) begin
      reg_write(6'h30, 8'(pages[i]));
      @(negedge clk); cpu_addr = addrs[i]; #1;
      chk("R3 ext addr", ext_addr, exp_ext(pages[i], addrs[i]));
    end
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    reg_write(6'h30, 8'h15);
    reg_read(6'h30, d);
    chk("R4 page readback", d, 8'h15);
  endtask

  task automatic t_upper_bits();
    logic [7:0] d;
    reg_write(6'h30, 8'hC7);
    reg_read(6'h30, d);
    chk("R9 upper bits dropped", d, 8'h07);
  endtask

  task automatic t_timing();
    logic [7:0] d;
    reg_write(6'h30, 8'h03);
    @(negedge clk);
    cpu_addr = 16'h9234; reg_ofs = 6'h30; reg_wdata = 8'h2C; reg_wr = 1'b1; reg_rd = 1'b1;
    #1;
    chk("R5 old page before edge", ext_addr, exp_ext(3, 16'h9234));
    chk("R10 read during write", reg_rdata, 8'h03);
    @(posedge clk); #0.5;
    chk("R5 new page after edge", ext_addr, exp_ext(6'h2C, 16'h9234));
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
    reg_read(6'h30, d);
    chk("R5 stored page", d, 8'h2C);
  endtask

  task automatic t_size_regs();
    logic [7:0] d;
    reg_read(6'h1C, d); chk("R6 size0", d, 8'h25);
    reg_read(6'h1D, d); chk("R6 size1", d, 8'h81);
    reg_write(6'h1C, 8'hFF); reg_write(6'h1D, 8'h00);
    reg_read(6'h1C, d); chk("R6 size0 after write", d, 8'h25);
    reg_read(6'h1D, d); chk("R6 size1 after write", d, 8'h81);
  endtask

  task automatic t_other_ofs();
    logic [7:0] d;
    reg_write(6'h30, 8'h11);
    reg_write(6'h31, 8'h22);
    reg_write(6'h10, 8'h33);
    reg_read(6'h30, d); chk("R7 page unchanged", d, 8'h11);
    reg_read(6'h31, d); chk("R7 other offset reads 0", d, 0);
    reg_read(6'h00, d); chk("R7 offset 0 reads 0", d, 0);
  endtask

  task automatic t_rd_idle();
    @(negedge clk);
    reg_rd = 1'b0;
    for (int o = 0; o < 64; o += 7) begin
      reg_ofs = 6'(o); #0.2;
      chk("R8 idle rdata", reg_rdata, 0);
    end
    reg_ofs = 6'h30; #0.2; chk("R8 idle rdata page ofs", reg_rdata, 0);
    reg_ofs = 6'h1D; #0.2; chk("R8 idle rdata size ofs", reg_rdata, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_translate();
    t_write_read();
    t_upper_bits();
    t_timing();
    t_size_regs();
    t_other_ofs();
    t_rd_idle();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule